// File: doc/BRIEF.md
# Multi-Mode Position Pulse Counter

This block keeps a 32-bit position for a motion axis from two encoder lines, A and B. A 2-bit mode selects how the lines are read. Mode 0 is x4 quadrature: every edge of either line counts, and the Gray-code order gives the direction. Mode 1 is step plus direction. Modes 2 and 3 count up only or down only on line A. Both lines pass through a two-flop synchronizer, and edges are found by comparing the synchronized level with its value one clock earlier.

Software reaches the block through a small word-addressed register port. Through it, software sets the mode, the edge-rate bit, the counter enable and a ceiling value, and it reads or overwrites the position. Software may only write a position that lies within the ceiling. Counting wraps between 0 and the ceiling in both directions. In quadrature mode, a transition where both lines change at once is dropped and sets a sticky error bit.

Top module: `pcnt_top`

## Requirements
- R1: After reset the position reads 0, the ceiling reads 0xFFFFFFFF, the decoder word reads 0 (quadrature mode) and the control word reads 0 (counting off, no error).
- R2: In mode 0, the line sequence {A,B} = 00,10,11,01,00 gives one increment per step.
- R3: In mode 0, the sequence {A,B} = 00,01,11,10,00 gives one decrement per step.
- R4: In mode 0, a step where A and B both change gives no count. It sets bit 15 of the control word, and that bit stays set until reset while later legal steps still count.
- R5: In mode 1, only rising edges of A count: up when B is high, down when B is low. Changes of B alone and falling edges of A give no count.
- R6: In mode 2, line A increments the position and B is ignored. With decoder bit 11 set, both edges of A count; with it clear, only rising edges count.
- R7: In mode 3, line A decrements the position and B is ignored, with the same edge selection through decoder bit 11.
- R8: While control bit 3 is clear, edges on A and B leave the position unchanged.
- R9: Incrementing from the ceiling gives 0, and decrementing from 0 gives the ceiling.
- R10: A position write with a value above the ceiling is refused and leaves the position unchanged. A write at or below the ceiling is loaded.
- R11: An accepted position write wins over a count event in the same cycle.
- R12: The register map is as follows. Address 0 is the position (read/write) and address 1 is the ceiling (read/write). Address 2 is the decoder word: mode in bits 15:14, both-edge select in bit 11, all other bits read 0. Address 3 is the control word: enable in bit 3 and the read-only error flag in bit 15, all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder line A, asynchronous |
| b_i | input | 1 | Encoder line B, asynchronous |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data for addr_i, combinational |

## Verification
The main stimulus is a walk through all four modes from a known position. The same line patterns are reused across modes so that each mode's reading can be told apart. A forward and a reverse Gray sequence separate the two quadrature directions. Changes on B alone, and falling edges of A, show whether the step/direction mode and the rising-only setting really ignore them. The both-edge setting is checked against the rising-only setting on identical A toggles. Directed steps then drive a simultaneous A/B change, a refused write above the ceiling, wraps at both ends, and a write that lands in the same cycle as a count.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_PDIR = 2'd1,
    MODE_UP   = 2'd2,
    MODE_DOWN = 2'd3
  } cnt_mode_e;

  localparam logic [1:0] ADDR_POS  = 2'd0;
  localparam logic [1:0] ADDR_CEIL = 2'd1;
  localparam logic [1:0] ADDR_DEC  = 2'd2;
  localparam logic [1:0] ADDR_CTL  = 2'd3;

  localparam int MODE_LSB = 14;
  localparam int EDGE_BIT = 11;
  localparam int EN_BIT   = 3;
  localparam int ERR_BIT  = 15;

  localparam int LINE_A = 0;
  localparam int LINE_B = 1;
endpackage

// File: rtl/pcnt_sync_edge.sv
module pcnt_sync_edge #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    logic              pv_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
        pv_q <= 1'b0;
      end else begin
        sh_q <= {sh_q[STAGES-2:0], raw_i[g]};
        pv_q <= sh_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = sh_q[STAGES-1];
    assign prev_o[g] = pv_q;
  end
endmodule

// File: rtl/pcnt_decode.sv
module pcnt_decode
  import pcnt_pkg::*;
(
  input  cnt_mode_e  mode_i,
  input  logic       both_i,
  input  logic       en_i,
  input  logic [1:0] cur_i,
  input  logic [1:0] prev_i,
  output logic       inc_o,
  output logic       dec_o,
  output logic       illegal_o
);
  logic a_ch, b_ch, a_rise, a_ev, quad_up;

  assign a_ch   = cur_i[LINE_A] ^ prev_i[LINE_A];
  assign b_ch   = cur_i[LINE_B] ^ prev_i[LINE_B];
  assign a_rise = cur_i[LINE_A] & ~prev_i[LINE_A];
  assign a_ev   = both_i ? a_ch : a_rise;
  // forward order 00->10->11->01 : new A differs from old B
  assign quad_up = cur_i[LINE_A] ^ prev_i[LINE_B];

  always_comb begin
    inc_o     = 1'b0;
    dec_o     = 1'b0;
    illegal_o = 1'b0;
    if (en_i) begin
      unique case (mode_i)
        MODE_QUAD: begin
          if (a_ch && b_ch) illegal_o = 1'b1;
          else if (a_ch || b_ch) begin
            inc_o = quad_up;
            dec_o = ~quad_up;
          end
        end
        MODE_PDIR: begin
          inc_o = a_rise & cur_i[LINE_B];
          dec_o = a_rise & ~cur_i[LINE_B];
        end
        MODE_UP:   inc_o = a_ev;
        MODE_DOWN: dec_o = a_ev;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcnt_regs.sv
module pcnt_regs
  import pcnt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cnt_mode_e         mode_o,
  output logic              both_o,
  output logic              en_o,
  output logic [DATA_W-1:0] ceil_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_QUAD;
      both_o <= 1'b0;
      en_o   <= 1'b0;
      ceil_o <= '1;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_CEIL: ceil_o <= wdata_i;
        ADDR_DEC: begin
          mode_o <= cnt_mode_e'(wdata_i[MODE_LSB +: 2]);
          both_o <= wdata_i[EDGE_BIT];
        end
        ADDR_CTL: en_o <= wdata_i[EN_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcnt_position.sv
module pcnt_position #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] ceil_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] pos_o
);
  logic load_ok;
  assign load_ok = load_i && (load_val_i <= ceil_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_o <= '0;
    else if (load_ok)  pos_o <= load_val_i;
    else if (inc_i)    pos_o <= (pos_o == ceil_i) ? '0 : pos_o + 1'b1;
    else if (dec_i)    pos_o <= (pos_o == '0) ? ceil_i : pos_o - 1'b1;
  end
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
  import pcnt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int LINES = 2;

  cnt_mode_e         mode;
  logic              both, cnt_en;
  logic [DATA_W-1:0] ceil_q, pos_q;
  logic [LINES-1:0]  lvl, prev;
  logic              inc, dec, illegal, err_q, wr_pos;

  pcnt_sync_edge #(.N(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .raw_i  ({b_i, a_i}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  pcnt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .mode_o (mode),
    .both_o (both),
    .en_o   (cnt_en),
    .ceil_o (ceil_q)
  );

  pcnt_decode u_dec (
    .mode_i    (mode),
    .both_i    (both),
    .en_i      (cnt_en),
    .cur_i     (lvl),
    .prev_i    (prev),
    .inc_o     (inc),
    .dec_o     (dec),
    .illegal_o (illegal)
  );

  assign wr_pos = wr_i && (addr_i == ADDR_POS);

  pcnt_position #(.W(DATA_W)) u_pos (
    .clk_i, .rst_ni,
    .load_i     (wr_pos),
    .load_val_i (wdata_i),
    .ceil_i     (ceil_q),
    .inc_i      (inc),
    .dec_i      (dec),
    .pos_o      (pos_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (illegal) err_q <= 1'b1;
  end

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      ADDR_POS:  rd_data_o = pos_q;
      ADDR_CEIL: rd_data_o = ceil_q;
      ADDR_DEC: begin
        rd_data_o[MODE_LSB +: 2] = mode;
        rd_data_o[EDGE_BIT]      = both;
      end
      ADDR_CTL: begin
        rd_data_o[EN_BIT]  = cnt_en;
        rd_data_o[ERR_BIT] = err_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_pos,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] ceil_v,
  input logic [DATA_W-1:0] pos,
  input logic              inc,
  input logic              dec,
  input logic              cnt_en,
  input logic [1:0]        lvl,
  input logic [1:0]        prev,
  input logic [1:0]        mode,
  input logic              err
);
  // R8
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en && !wr_pos) |=> $stable(pos));

  // R10
  refuse_big_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pos && wdata > ceil_v && !inc && !dec) |=> $stable(pos));

  // R11
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pos && wdata <= ceil_v) |=> pos == $past(wdata));

  // R9
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !wr_pos && pos == ceil_v) |=> pos == '0);

  // R9
  wrap_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec && !wr_pos && pos == '0) |=> pos == $past(ceil_v));

  // R4
  illegal_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd0 && (lvl ^ prev) == 2'b11) |-> !(inc || dec));

  // R4
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |=> err);

  // R2
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inc, dec}));
endmodule

bind pcnt_top pcnt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_pos (wr_pos),
  .wdata  (wdata_i),
  .ceil_v (ceil_q),
  .pos    (pos_q),
  .inc    (inc),
  .dec    (dec),
  .cnt_en (cnt_en),
  .lvl    (lvl),
  .prev   (prev),
  .mode   (mode),
  .err    (err_q)
);

// File: tb/pcnt_top_tb.sv
`timescale 1ns/1ps
module pcnt_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a = 1'b0, b = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pcnt_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rd_data_o(rdata)
  );

  // {mode, both_edges, a, b, expected position}
  localparam int NV = 25;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0,1'b0,1'b1,1'b0,16'd101}, {2'd0,1'b0,1'b1,1'b1,16'd102},
    {2'd0,1'b0,1'b0,1'b1,16'd103}, {2'd0,1'b0,1'b0,1'b0,16'd104},
    {2'd0,1'b0,1'b0,1'b1,16'd103}, {2'd0,1'b0,1'b1,1'b1,16'd102},
    {2'd0,1'b0,1'b1,1'b0,16'd101}, {2'd0,1'b0,1'b0,1'b0,16'd100},
    {2'd1,1'b0,1'b0,1'b1,16'd100}, {2'd1,1'b0,1'b1,1'b1,16'd101},
    {2'd1,1'b0,1'b0,1'b1,16'd101}, {2'd1,1'b0,1'b0,1'b0,16'd101},
    {2'd1,1'b0,1'b1,1'b0,16'd100}, {2'd1,1'b0,1'b0,1'b0,16'd100},
    {2'd2,1'b0,1'b1,1'b0,16'd101}, {2'd2,1'b0,1'b0,1'b1,16'd101},
    {2'd2,1'b0,1'b1,1'b0,16'd102}, {2'd2,1'b0,1'b0,1'b0,16'd102},
    {2'd2,1'b1,1'b1,1'b0,16'd103}, {2'd2,1'b1,1'b0,1'b0,16'd104},
    {2'd2,1'b1,1'b0,1'b1,16'd104}, {2'd3,1'b1,1'b1,1'b1,16'd103},
    {2'd3,1'b1,1'b0,1'b0,16'd102}, {2'd3,1'b0,1'b1,1'b0,16'd101},
    {2'd3,1'b0,1'b0,1'b0,16'd101}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] ad, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = ad; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] ad, output logic [31:0] d);
    @(negedge clk);
    addr = ad;
    #1 d = rdata;
  endtask

  task automatic set_ab(input logic na, input logic nb);
    @(negedge clk);
    a = na; b = nb;
    repeat (3) @(posedge clk);
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R2/R3 quad";
      2'd1: return "R5 step-dir";
      2'd2: return "R6 up";
      default: return "R7 down";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hang, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [1:0]  cur_mode;
    logic        cur_both;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    reg_rd(2'd0, v); check("R1 pos", v, 32'd0);
    reg_rd(2'd1, v); check("R1 ceil", v, 32'hFFFF_FFFF);
    reg_rd(2'd2, v); check("R1 dec word", v, 32'd0);
    reg_rd(2'd3, v); check("R1 ctl word", v, 32'd0);

    reg_wr(2'd3, 32'h8);
    reg_wr(2'd0, 32'd100);
    cur_mode = 2'd0; cur_both = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20:19] != cur_mode || VEC[i][18] != cur_both) begin
        cur_mode = VEC[i][20:19]; cur_both = VEC[i][18];
        reg_wr(2'd2, {16'd0, cur_mode, 2'b00, cur_both, 11'd0});
      end
      set_ab(VEC[i][17], VEC[i][16]);
      reg_rd(2'd0, v);
      check(tag_of(cur_mode), v, {16'd0, VEC[i][15:0]});
    end

    // R8 disabled: position holds (down mode, rising only)
    reg_wr(2'd3, 32'h0);
    set_ab(1'b1, 1'b0); set_ab(1'b0, 1'b1);
    reg_rd(2'd0, v); check("R8 hold", v, 32'd101);
    reg_wr(2'd3, 32'h8);
    set_ab(1'b0, 1'b0);

    // R12 field layout
    reg_wr(2'd2, 32'hFFFF_FFFF);
    reg_rd(2'd2, v); check("R12 dec word", v, 32'h0000_C800);
    reg_rd(2'd3, v); check("R12 ctl word", v, 32'h0000_0008);

    // R10 ceiling guard
    reg_wr(2'd1, 32'd50);
    reg_rd(2'd1, v); check("R12 ceil readback", v, 32'd50);
    reg_wr(2'd0, 32'd60);
    reg_rd(2'd0, v); check("R10 refused", v, 32'd101);
    reg_wr(2'd0, 32'd50);
    reg_rd(2'd0, v); check("R10 accepted", v, 32'd50);

    // R9 wrap both ways
    reg_wr(2'd2, 32'h0000_8000);
    set_ab(1'b1, 1'b0);
    reg_rd(2'd0, v); check("R9 up wrap", v, 32'd0);
    set_ab(1'b0, 1'b0);
    reg_wr(2'd2, 32'h0000_C000);
    set_ab(1'b1, 1'b0);
    reg_rd(2'd0, v); check("R9 down wrap", v, 32'd50);
    set_ab(1'b0, 1'b0);

    // R11 write in the same cycle as a count event
    @(negedge clk) a = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin wr = 1'b1; addr = 2'd0; wdata = 32'd7; end
    @(posedge clk);
    #1 wr = 1'b0;
    reg_rd(2'd0, v); check("R11 write priority", v, 32'd7);
    set_ab(1'b0, 1'b0);
    reg_rd(2'd0, v); check("R7 falling ignored", v, 32'd7);

    // R4 illegal quadrature step
    reg_wr(2'd2, 32'h0);
    set_ab(1'b1, 1'b1);
    reg_rd(2'd0, v); check("R4 no count", v, 32'd7);
    reg_rd(2'd3, v); check("R4 err set", v, 32'h0000_8008);
    set_ab(1'b1, 1'b0);
    reg_rd(2'd0, v); check("R4 later step counts", v, 32'd6);
    reg_rd(2'd3, v); check("R4 err sticky", v, 32'h0000_8008);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule